// File: doc/BRIEF.md
# Recency-Ordered Set-Associative Tag Lookup

This block is the tag side of a set-associative cache model whose only job is to count hits and misses. A requester presents a set number and a tag. The block answers hit or miss one cycle later, and in the same operation it updates that set's replacement order. No data, dirty state or refill traffic is kept. Each set holds its ways as a list ordered by recency. Slot 0 holds the most recently used tag and the last slot holds the least recently used one. A lookup moves the accessed tag to slot 0 by shifting the slots above it down by one place. A miss always allocates, whether the access is a read or a write. On a miss the least recently used tag drops off the end of the list.

The tag is the full line-block number, which is the address shifted right by log2 of the line size. The requester therefore computes both fields from the same block number: the set is the low bits of the block number and the tag is the whole of it. There are no valid bits. After reset every slot holds zero, so block 0 counts as resident everywhere. Associativity, set count and tag width are compile-time parameters. The set count must be a power of two, and a single-way (direct-mapped) build is supported.

Top module: `mru_tag_store`

## Requirements
- R1: After rst_ni is released, req_ready_o stays low for exactly SETS rising clock edges while the sets are cleared one per cycle. After that it is high and stays high.
- R2: After clearing, every slot of every set holds tag 0. A lookup of tag 0 in any set hits.
- R3: A lookup whose tag is in slot 0 of its set is a hit, and it leaves the order of that set unchanged.
- R4: A lookup whose tag is in slot i > 0 is a hit. Slots 0..i-1 move down by one and the tag goes into slot 0.
- R5: A lookup whose tag is absent is a miss. Every slot moves down by one, the tag in the last slot is discarded, and the new tag goes into slot 0.
- R6: A request is accepted when req_valid_i and req_ready_o are both high at a rising edge. rsp_valid_o is high in exactly the cycle after each accepted request, and low otherwise.
- R7: A request presented while req_ready_o is low is not accepted. It produces no response and changes no set.
- R8: A lookup changes only the set it names. The order held in every other set is preserved.
- R9: rsp_miss_o is 1 for a miss and 0 for a hit while rsp_valid_o is high. It is 0 whenever rsp_valid_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset; starts the clearing sweep |
| req_valid_i | input | 1 | Lookup request present |
| req_ready_o | output | 1 | Block can accept a lookup this cycle |
| req_set_i | input | SET_W | Set number, the low bits of the block number |
| req_tag_i | input | TAG_W | Tag: the full line-block number |
| rsp_valid_o | output | 1 | Response for the lookup accepted in the previous cycle |
| rsp_miss_o | output | 1 | 1 = miss, 0 = hit |

## Verification
The bound checker watches the handshake on every cycle. It checks the exact length of the clearing window, that ready never drops once it is raised, and that a response follows each acceptance and nothing else. It also checks that the miss flag stays quiet outside a response. The recency order itself is not visible at the ports, so the bench's per-set list model has to cover it. The bench's scenarios show promotion from the middle and from the tail of the list and eviction of the oldest tag. They also show that block 0 is resident after clearing and that other sets keep their order, and long mixed runs check every response against the model.

// File: rtl/mru_pkg.sv
package mru_pkg;
  typedef struct packed {
    logic valid;
    logic miss;
  } lookup_rsp_t;

  function automatic int unsigned pos_width(int unsigned ways);
    return (ways > 1) ? $clog2(ways) : 1;
  endfunction
endpackage

// File: rtl/mru_first_match.sv
module mru_first_match #(
  parameter int unsigned WAYS  = 4,
  parameter int unsigned POS_W = 2
) (
  input  logic [WAYS-1:0]  match_i,
  output logic             found_o,
  output logic [POS_W-1:0] pos_o
);
  // lowest matching slot wins
  always_comb begin
    found_o = 1'b0;
    pos_o   = '0;
    for (int k = WAYS - 1; k >= 0; k--) begin
      if (match_i[k]) begin
        found_o = 1'b1;
        pos_o   = POS_W'(k);
      end
    end
  end
endmodule

// File: rtl/mru_set_update.sv
module mru_set_update #(
  parameter int unsigned WAYS  = 4,
  parameter int unsigned TAG_W = 16,
  parameter int unsigned POS_W = 2
) (
  input  logic [WAYS-1:0][TAG_W-1:0] row_i,
  input  logic [TAG_W-1:0]           tag_i,
  output logic [WAYS-1:0][TAG_W-1:0] row_o,
  output logic                       hit_o
);
  logic [WAYS-1:0]  match;
  logic [POS_W-1:0] pos;

  for (genvar j = 0; j < WAYS; j++) begin : g_cmp
    assign match[j] = (row_i[j] == tag_i);
  end

  mru_first_match #(.WAYS(WAYS), .POS_W(POS_W)) u_first (
    .match_i (match),
    .found_o (hit_o),
    .pos_o   (pos)
  );

  for (genvar j = 0; j < WAYS; j++) begin : g_shift
    if (j == 0) begin : g_head
      assign row_o[0] = tag_i;
    end else begin : g_body
      localparam logic [POS_W-1:0] SLOT = POS_W'(j);
      // slots at or above the hit (all on miss) take their upper neighbour
      assign row_o[j] = (!hit_o || (SLOT <= pos)) ? row_i[j-1] : row_i[j];
    end
  end
endmodule

// File: rtl/mru_clear_seq.sv
module mru_clear_seq #(
  parameter int unsigned SETS  = 16,
  parameter int unsigned SET_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic             busy_o,
  output logic [SET_W-1:0] idx_o
);
  localparam logic [SET_W-1:0] LAST = SET_W'(SETS - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b1;
      idx_o  <= '0;
    end else if (busy_o) begin
      idx_o <= idx_o + 1'b1;
      if (idx_o == LAST) busy_o <= 1'b0;
    end
  end
endmodule

// File: rtl/mru_tag_store.sv
module mru_tag_store
  import mru_pkg::*;
#(
  parameter int unsigned WAYS  = 4,
  parameter int unsigned SETS  = 16,
  parameter int unsigned TAG_W = 16,
  localparam int unsigned SET_W = (SETS > 1) ? $clog2(SETS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [SET_W-1:0] req_set_i,
  input  logic [TAG_W-1:0] req_tag_i,
  output logic             rsp_valid_o,
  output logic             rsp_miss_o
);
  localparam int unsigned POS_W = pos_width(WAYS);

  logic [WAYS-1:0][TAG_W-1:0] row_q [SETS];
  logic [WAYS-1:0][TAG_W-1:0] row_rd, row_nx;
  logic                       hit, accept, clr_busy;
  logic [SET_W-1:0]           clr_idx;
  lookup_rsp_t                rsp_q;

  mru_clear_seq #(.SETS(SETS), .SET_W(SET_W)) u_clear (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .busy_o (clr_busy),
    .idx_o  (clr_idx)
  );

  assign req_ready_o = !clr_busy;
  assign accept      = req_valid_i && req_ready_o;
  assign row_rd      = row_q[req_set_i];

  mru_set_update #(.WAYS(WAYS), .TAG_W(TAG_W), .POS_W(POS_W)) u_update (
    .row_i (row_rd),
    .tag_i (req_tag_i),
    .row_o (row_nx),
    .hit_o (hit)
  );

  // tag rows carry no reset; the sweep zeroes them
  for (genvar s = 0; s < SETS; s++) begin : g_set
    localparam logic [SET_W-1:0] SID = SET_W'(s);
    always_ff @(posedge clk_i) begin
      if (clr_busy) begin
        if (clr_idx == SID) row_q[s] <= '0;
      end else if (accept && (req_set_i == SID)) begin
        row_q[s] <= row_nx;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_q <= '0;
    end else begin
      rsp_q.valid <= accept;
      rsp_q.miss  <= accept && !hit;
    end
  end

  assign rsp_valid_o = rsp_q.valid;
  assign rsp_miss_o  = rsp_q.miss;
endmodule

// File: rtl/mru_tag_store_chk.sv
module mru_tag_store_chk #(
  parameter int unsigned SETS = 16
) (
  input logic clk_i,
  input logic rst_ni,
  input logic req_valid_i,
  input logic req_ready_o,
  input logic rsp_valid_o,
  input logic rsp_miss_o
);
  localparam int unsigned CW = $clog2(SETS + 1) + 1;
  logic [CW-1:0] edges_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) edges_q <= '0;
    else if (edges_q < CW'(SETS)) edges_q <= edges_q + 1'b1;
  end

  // R1
  clear_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o == (edges_q >= CW'(SETS)));

  // R1
  ready_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |=> req_ready_o);

  // R6
  rsp_follows_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> rsp_valid_o);

  // R7
  no_rsp_when_stalled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_valid_i && req_ready_o) |=> !rsp_valid_o);

  // R9
  miss_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsp_valid_o |-> !rsp_miss_o);
endmodule

bind mru_tag_store mru_tag_store_chk #(.SETS(SETS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .rsp_valid_o (rsp_valid_o),
  .rsp_miss_o  (rsp_miss_o)
);

// File: tb/tb_mru_tag_store.sv
module tb_mru_tag_store;
  localparam int WAYS  = 4;
  localparam int SETS  = 16;
  localparam int TAG_W = 16;
  localparam int SET_W = $clog2(SETS);

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             req_valid_i = 1'b0;
  logic             req_ready_o;
  logic [SET_W-1:0] req_set_i = '0;
  logic [TAG_W-1:0] req_tag_i = '0;
  logic             rsp_valid_o;
  logic             rsp_miss_o;

  int checks = 0;
  int failures = 0;
  int edges = 0;
  bit done = 0;
  int q [SETS][$];

  mru_tag_store #(.WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W)) dut (.*);

  always #10 clk_i = ~clk_i;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // behavioural list model: returns miss and the slot that matched
  function automatic bit model(int s, int t, output int pos);
    pos = -1;
    foreach (q[s][i]) if (pos < 0 && q[s][i] == t) pos = i;
    if (pos >= 0) begin
      q[s].delete(pos);
      q[s].push_front(t);
      return 1'b0;
    end
    q[s].push_front(t);
    void'(q[s].pop_back());
    return 1'b1;
  endfunction

  // label "" -> pick R3/R4/R5 from the model outcome
  task automatic cyc(bit v, int s, int t, string label);
    bit rdy, acc, exp_miss;
    int pos;
    string lab;
    rdy = (edges >= SETS);
    check("R1", req_ready_o, rdy);
    req_valid_i = v;
    req_set_i   = SET_W'(s);
    req_tag_i   = TAG_W'(t);
    acc = v && rdy;
    exp_miss = 1'b0;
    pos = -1;
    if (acc) exp_miss = model(s, t, pos);
    @(negedge clk_i);
    edges++;
    req_valid_i = 1'b0;
    check((v && !rdy) ? "R7" : "R6", rsp_valid_o, acc);
    if (acc) begin
      lab = label;
      if (lab == "") lab = exp_miss ? "R5" : (pos == 0 ? "R3" : "R4");
      check(lab, rsp_miss_o, exp_miss);
    end else begin
      check("R9", rsp_miss_o, 0);
    end
  endtask

  initial begin
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++) q[s].push_back(0);
    repeat (3) @(negedge clk_i);
    check("R1", req_ready_o, 0);
    check("R6", rsp_valid_o, 0);
    rst_ni = 1'b1;
    // requests during the clearing sweep
    for (int i = 0; i < SETS; i++) cyc(1'b1, 2, 99, "R7");
    cyc(1'b0, 0, 0, "R1");
    // block 0 resident everywhere after clearing
    cyc(1'b1, 0, 0, "R2");
    cyc(1'b1, 9, 0, "R2");
    cyc(1'b1, 2, 99, "R7"); // stalled request earlier must not have installed 99
    // fill set 3: order becomes 13,12,11,10
    cyc(1'b1, 3, 10, "R5");
    cyc(1'b1, 3, 11, "R5");
    cyc(1'b1, 3, 12, "R5");
    cyc(1'b1, 3, 13, "R5");
    cyc(1'b1, 5, 7, "R5");
    cyc(1'b1, 3, 13, "R3");
    cyc(1'b1, 3, 13, "R3");
    cyc(1'b1, 3, 10, "R4");  // from tail to front: 10,13,12,11
    cyc(1'b1, 3, 12, "R4");  // 12,10,13,11
    cyc(1'b1, 3, 20, "R5");  // evicts 11
    cyc(1'b1, 3, 11, "R5");  // 11 gone
    cyc(1'b1, 3, 0, "R5");   // zeros all evicted by now
    cyc(1'b1, 5, 7, "R8");   // set 5 kept its order
    cyc(1'b1, 5, 0, "R8");
    // back-to-back, idle gaps and mixed traffic
    for (int i = 0; i < 3000; i++) begin
      cyc($urandom_range(0, 3) != 0, $urandom_range(0, 3), $urandom_range(0, 6), "");
    end
    for (int i = 0; i < 500; i++) cyc(1'b1, 6, $urandom_range(0, 4), "");
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", edges, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule